// File: doc/BRIEF.md
# Multi-lane 8b/10b Transmit Coder with Raw Bypass

This block sits on the transmit side of a multi-lane serial link, between the host data bus and each lane's serializer. Every host transfer on a lane carries two 10-bit words: the one captured on the rising edge of the host transmit clock and the one captured on the falling edge. The block holds that pair and hands the words one at a time, rising word first, into a single-rate clock running at twice the host rate. Each word becomes one 10-bit code group for the serializer.

A mode pin picks how a word is treated. In raw mode the word is taken as a code group that is already encoded and is passed through unchanged. In encode mode only the low byte is data, bit 8 asks for a control (K) character, and bit 9 is ignored. Each lane keeps its own running disparity and chooses every group from the column that keeps the line DC balanced. A second pin picks sync mode, in which every lane takes its capture strobe from lane 0, or independent mode, in which each lane uses its own strobe.

Both edges of the block use valid/ready. A host transfer on a lane completes on a clock edge where that lane's strobe and `in_ready` are both high. A code group leaves on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low the lane holds its group, and `in_ready` falls once the lane cannot take another pair. One lane can accept a new pair every second cycle, which keeps its output stream full.

Top module: `txc_top`

## Requirements
- R1: When `raw_mode` is high as a word moves into a lane's output register, the code group equals the 10 input bits unchanged. Bit 0 of every code group is the first bit to be serialized.
- R2: In encode mode with bit 8 low, byte bits [7:0] are coded as data character D.x.y, where x is bits [4:0] and y is bits [7:5]. The group is laid out as abcdei fghj in output bits 0 through 9, with bit 0 = a.
- R3: In encode mode with bit 8 high and a byte among 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC, 0xF7, 0xFB, 0xFD, 0xFE, the matching K group is emitted and `bad_k` is low.
- R4: In encode mode, input bit 9 has no effect on the emitted group, the flag or the disparity.
- R5: Running disparity is negative after reset. A group is taken from the column of the current disparity. After a group with six ones it is positive, after four ones it is negative, and after five ones it is unchanged. Raw groups leave it unchanged.
- R6: A K request for any other byte emits the K30.7 group for the current disparity, and `bad_k` is high together with that group.
- R7: Each accepted transfer yields exactly two groups, the rising word's group first and then the falling word's, in acceptance order, with none lost or repeated.
- R8: While `out_valid` is high and `out_ready` low, `out_valid`, the code group and `bad_k` hold steady on the next cycle.
- R9: With `sync_mode` high, every lane's strobe is `in_valid[0]`. The other `in_valid` bits are ignored, and all bits of `in_ready` are equal.
- R10: With `sync_mode` low, each lane accepts on its own `in_valid` bit and `in_ready` bit.
- R11: After reset, every `out_valid` bit is low and every `in_ready` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_mode | input | 1 | 1: forward words as encoded groups; 0: 8b/10b encode |
| sync_mode | input | 1 | 1: all lanes strobed by lane 0; 0: per-lane strobes |
| in_valid | input | LANES | Per-lane host transfer strobe |
| in_ready | output | LANES | Per-lane room for a new word pair |
| in_rise | input | 10*LANES | Rising-edge words, lane i at bits [10i+9:10i] |
| in_fall | input | 10*LANES | Falling-edge words, same packing |
| out_valid | output | LANES | Code group present |
| out_ready | input | LANES | Serializer takes the group |
| out_code | output | 10*LANES | Code groups, bit 0 of each lane sent first |
| bad_k | output | LANES | Group replaces an illegal K request |

## Verification
On every cycle, assertions check that a stalled group holds steady and that an encoded group never drives disparity past one step in the wrong direction. They also check that raw groups leave disparity alone, that a flagged group is always one of the two K30.7 patterns, that the pair buffer never takes a pair it has no room for, and that sync mode keeps the ready bits equal. Only the bench's scenarios can show that each group matches the code table, the exact K patterns, the rise-before-fall order across random back-pressure, and that bit 9 and the other lanes' strobes are ignored. The bench checks these against its own reference encoder and a scoreboard for each lane.

// File: rtl/txc_pkg.sv
package txc_pkg;
  localparam int unsigned GRP_W  = 10;
  localparam int unsigned BYTE_W = 8;

  // 5b/6b data code, negative-disparity column, a is the MSB (abcdei)
  function automatic logic [5:0] six_neg(input logic [4:0] x);
    logic [5:0] r;
    case (x)
      5'd0:  r = 6'b100111; 5'd1:  r = 6'b011101; 5'd2:  r = 6'b101101;
      5'd3:  r = 6'b110001; 5'd4:  r = 6'b110101; 5'd5:  r = 6'b101001;
      5'd6:  r = 6'b011001; 5'd7:  r = 6'b111000; 5'd8:  r = 6'b111001;
      5'd9:  r = 6'b100101; 5'd10: r = 6'b010101; 5'd11: r = 6'b110100;
      5'd12: r = 6'b001101; 5'd13: r = 6'b101100; 5'd14: r = 6'b011100;
      5'd15: r = 6'b010111; 5'd16: r = 6'b011011; 5'd17: r = 6'b100011;
      5'd18: r = 6'b010011; 5'd19: r = 6'b110010; 5'd20: r = 6'b001011;
      5'd21: r = 6'b101010; 5'd22: r = 6'b011010; 5'd23: r = 6'b111010;
      5'd24: r = 6'b110011; 5'd25: r = 6'b100110; 5'd26: r = 6'b010110;
      5'd27: r = 6'b110110; 5'd28: r = 6'b001110; 5'd29: r = 6'b101110;
      5'd30: r = 6'b011110; default: r = 6'b101011;
    endcase
    return r;
  endfunction

  // 3b/4b data code, negative column, primary .7 form (fghj)
  function automatic logic [3:0] four_neg(input logic [2:0] y);
    logic [3:0] r;
    case (y)
      3'd0: r = 4'b1011; 3'd1: r = 4'b1001; 3'd2: r = 4'b0101; 3'd3: r = 4'b1100;
      3'd4: r = 4'b1101; 3'd5: r = 4'b1010; 3'd6: r = 4'b0110; default: r = 4'b1110;
    endcase
    return r;
  endfunction

  // fghj tail of K28.y when the group starts from negative disparity
  function automatic logic [3:0] k28_tail(input logic [2:0] y);
    logic [3:0] r;
    case (y)
      3'd0: r = 4'b0100; 3'd1: r = 4'b1001; 3'd2: r = 4'b0101; 3'd3: r = 4'b0011;
      3'd4: r = 4'b0010; 3'd5: r = 4'b1010; 3'd6: r = 4'b0110; default: r = 4'b1000;
    endcase
    return r;
  endfunction

  function automatic logic k_legal(input logic [7:0] b);
    return (b[4:0] == 5'd28) ||
           (b == 8'hF7) || (b == 8'hFB) || (b == 8'hFD) || (b == 8'hFE);
  endfunction

  // K30.7 in output bit order (bit 0 = a), both columns
  localparam logic [GRP_W-1:0] K307_NEG = 10'b0001011110;
  localparam logic [GRP_W-1:0] K307_POS = 10'b1110100001;
endpackage

// File: rtl/txc_enc.sv
module txc_enc
  import txc_pkg::*;
(
  input  logic [GRP_W-1:0] word,
  input  logic             raw,
  input  logic             rd_pos,
  output logic [GRP_W-1:0] code,
  output logic             rd_next,
  output logic             k_bad
);
  logic [BYTE_W-1:0] kb;
  logic [4:0]        x;
  logic [2:0]        y;
  logic [5:0]        c6m, c6;
  logic [3:0]        t4, c4;
  logic              rd6, alt7;
  logic [GRP_W-1:0]  s;   // abcdei fghj, a in the MSB
  int                ones;

  always_comb begin
    kb    = word[7:0];
    k_bad = 1'b0;
    c6m   = '0;
    c6    = '0;
    t4    = '0;
    c4    = '0;
    rd6   = rd_pos;
    alt7  = 1'b0;
    if (word[8] && !k_legal(word[7:0])) begin
      kb    = 8'hFE;
      k_bad = 1'b1;
    end
    x = kb[4:0];
    y = kb[7:5];
    if (word[8]) begin
      if (x == 5'd28) s = {6'b001111, k28_tail(y)};
      else            s = {six_neg(x), 4'b1000};
      if (rd_pos) s = ~s;
    end else begin
      c6m = six_neg(x);
      if ($countones(c6m) == 3) begin
        c6  = (x == 5'd7 && rd_pos) ? ~c6m : c6m;
        rd6 = rd_pos;
      end else begin
        c6  = rd_pos ? ~c6m : c6m;
        rd6 = !rd_pos;
      end
      alt7 = rd6 ? (x == 5'd11 || x == 5'd13 || x == 5'd14)
                 : (x == 5'd17 || x == 5'd18 || x == 5'd20);
      t4 = (y == 3'd7 && alt7) ? 4'b0111 : four_neg(y);
      c4 = (rd6 && (y == 3'd0 || y == 3'd3 || y == 3'd4 || y == 3'd7)) ? ~t4 : t4;
      s  = {c6, c4};
    end
    for (int i = 0; i < GRP_W; i++) code[i] = s[GRP_W-1-i];
    ones = $countones(s);
    if (ones > 5)      rd_next = 1'b1;
    else if (ones < 5) rd_next = 1'b0;
    else               rd_next = rd_pos;
    if (raw) begin
      code    = word;
      rd_next = rd_pos;
      k_bad   = 1'b0;
    end
  end
endmodule

// File: rtl/txc_pair_buf.sv
module txc_pair_buf
  import txc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [GRP_W-1:0] rise,
  input  logic [GRP_W-1:0] fall,
  input  logic             pop,
  output logic             can_take,
  output logic             has_word,
  output logic [GRP_W-1:0] head
);
  logic [1:0]       cnt;
  logic [GRP_W-1:0] hold_r, hold_f;

  assign has_word = (cnt != 2'd0);
  assign head     = (cnt == 2'd2) ? hold_r : hold_f;
  assign can_take = (cnt == 2'd0) || (cnt == 2'd1 && pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      hold_r <= '0;
      hold_f <= '0;
    end else if (take) begin
      cnt    <= 2'd2;
      hold_r <= rise;
      hold_f <= fall;
    end else if (pop && has_word) begin
      cnt <= cnt - 2'd1;
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (cnt == 2'd0 || (cnt == 2'd1 && pop)));
  assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 2'd2);
endmodule

// File: rtl/txc_lane.sv
module txc_lane
  import txc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_mode,
  input  logic             take,
  input  logic [GRP_W-1:0] rise,
  input  logic [GRP_W-1:0] fall,
  output logic             can_take,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [GRP_W-1:0] out_code,
  output logic             bad_k
);
  logic             adv, pop, has_word, rd_q, rd_nx, kb_nx;
  logic [GRP_W-1:0] head, code_nx;

  assign adv = !out_valid || out_ready;
  assign pop = adv && has_word;

  txc_pair_buf u_buf (
    .clk(clk), .rst_n(rst_n), .take(take), .rise(rise), .fall(fall),
    .pop(pop), .can_take(can_take), .has_word(has_word), .head(head)
  );

  txc_enc u_enc (
    .word(head), .raw(raw_mode), .rd_pos(rd_q),
    .code(code_nx), .rd_next(rd_nx), .k_bad(kb_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      bad_k     <= 1'b0;
      rd_q      <= 1'b0;
    end else if (adv) begin
      out_valid <= has_word;
      if (has_word) begin
        out_code <= code_nx;
        bad_k    <= kb_nx;
        rd_q     <= rd_nx;
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(bad_k)));
  assert_disp_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !raw_mode && !rd_q) |=> ($countones(out_code) >= 5));
  assert_disp_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !raw_mode && rd_q) |=> ($countones(out_code) <= 5));
  assert_raw_keeps_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && raw_mode) |=> $stable(rd_q));
  assert_badk_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && bad_k) |-> (out_code == K307_NEG || out_code == K307_POS));
endmodule

// File: rtl/txc_top.sv
module txc_top
  import txc_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   raw_mode,
  input  logic                   sync_mode,
  input  logic [LANES-1:0]       in_valid,
  output logic [LANES-1:0]       in_ready,
  input  logic [LANES*GRP_W-1:0] in_rise,
  input  logic [LANES*GRP_W-1:0] in_fall,
  output logic [LANES-1:0]       out_valid,
  input  logic [LANES-1:0]       out_ready,
  output logic [LANES*GRP_W-1:0] out_code,
  output logic [LANES-1:0]       bad_k
);
  logic [LANES-1:0] lane_room, strobe, take;
  logic             all_room;

  assign all_room = &lane_room;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign strobe[i]   = sync_mode ? in_valid[0] : in_valid[i];
    assign in_ready[i] = sync_mode ? all_room : lane_room[i];
    assign take[i]     = strobe[i] && in_ready[i];

    txc_lane u_lane (
      .clk(clk), .rst_n(rst_n), .raw_mode(raw_mode), .take(take[i]),
      .rise(in_rise[i*GRP_W +: GRP_W]), .fall(in_fall[i*GRP_W +: GRP_W]),
      .can_take(lane_room[i]), .out_valid(out_valid[i]), .out_ready(out_ready[i]),
      .out_code(out_code[i*GRP_W +: GRP_W]), .bad_k(bad_k[i])
    );
  end

  assert_sync_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |-> (in_ready == '0 || in_ready == '1));
endmodule

// File: tb/txc_top_test.sv
module txc_top_test;
  localparam int L = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            raw_mode, sync_mode;
  logic [L-1:0]    in_valid, in_ready, out_valid, out_ready, bad_k;
  logic [L*10-1:0] in_rise, in_fall, out_code;

  int total = 0, bad = 0;
  bit done = 0;

  logic [9:0]  fq [L][256];
  int unsigned wp [L], rp [L];
  bit          rdm [L];
  bit          held_v [L];
  logic [9:0]  held_c [L];
  logic [9:0]  lg [64];
  int          lgn = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  txc_top uut (
    .clk(clk), .rst_n(rst_n), .raw_mode(raw_mode), .sync_mode(sync_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_rise(in_rise), .in_fall(in_fall),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code), .bad_k(bad_k)
  );

  task automatic chk(input bit ok, input string tag, input logic [10:0] act, input logic [10:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] t6(input logic [4:0] x);  // {neg, pos}
    case (x)
      5'd0:  return {6'b100111, 6'b011000}; 5'd1:  return {6'b011101, 6'b100010};
      5'd2:  return {6'b101101, 6'b010010}; 5'd3:  return {6'b110001, 6'b110001};
      5'd4:  return {6'b110101, 6'b001010}; 5'd5:  return {6'b101001, 6'b101001};
      5'd6:  return {6'b011001, 6'b011001}; 5'd7:  return {6'b111000, 6'b000111};
      5'd8:  return {6'b111001, 6'b000110}; 5'd9:  return {6'b100101, 6'b100101};
      5'd10: return {6'b010101, 6'b010101}; 5'd11: return {6'b110100, 6'b110100};
      5'd12: return {6'b001101, 6'b001101}; 5'd13: return {6'b101100, 6'b101100};
      5'd14: return {6'b011100, 6'b011100}; 5'd15: return {6'b010111, 6'b101000};
      5'd16: return {6'b011011, 6'b100100}; 5'd17: return {6'b100011, 6'b100011};
      5'd18: return {6'b010011, 6'b010011}; 5'd19: return {6'b110010, 6'b110010};
      5'd20: return {6'b001011, 6'b001011}; 5'd21: return {6'b101010, 6'b101010};
      5'd22: return {6'b011010, 6'b011010}; 5'd23: return {6'b111010, 6'b000101};
      5'd24: return {6'b110011, 6'b001100}; 5'd25: return {6'b100110, 6'b100110};
      5'd26: return {6'b010110, 6'b010110}; 5'd27: return {6'b110110, 6'b001001};
      5'd28: return {6'b001110, 6'b001110}; 5'd29: return {6'b101110, 6'b010001};
      5'd30: return {6'b011110, 6'b100001}; default: return {6'b101011, 6'b010100};
    endcase
  endfunction

  function automatic logic [7:0] t4(input logic [2:0] y, input bit alt);  // {neg, pos}
    if (alt) return {4'b0111, 4'b1000};
    case (y)
      3'd0: return {4'b1011, 4'b0100}; 3'd1: return {4'b1001, 4'b1001};
      3'd2: return {4'b0101, 4'b0101}; 3'd3: return {4'b1100, 4'b0011};
      3'd4: return {4'b1101, 4'b0010}; 3'd5: return {4'b1010, 4'b1010};
      3'd6: return {4'b0110, 4'b0110}; default: return {4'b1110, 4'b0001};
    endcase
  endfunction

  function automatic logic [7:0] kbyte(input int i);
    case (i)
      0: return 8'h1C; 1: return 8'h3C; 2: return 8'h5C; 3: return 8'h7C;
      4: return 8'h9C; 5: return 8'hBC; 6: return 8'hDC; 7: return 8'hFC;
      8: return 8'hF7; 9: return 8'hFB; 10: return 8'hFD; default: return 8'hFE;
    endcase
  endfunction

  // reference encoder: returns {bad_k, new_rd, code}, code bit 0 = a
  function automatic logic [11:0] ref_enc(input logic [9:0] w, input bit rdp);
    logic [7:0] b;
    logic [9:0] s, c;
    logic [11:0] p6;
    logic [7:0] p4;
    logic [5:0] c6;
    bit kbad, rd6, alt, nrd;
    int n;
    b = w[7:0];
    kbad = 0;
    if (w[8]) begin
      if (!(b[4:0] == 5'd28 || b == 8'hF7 || b == 8'hFB || b == 8'hFD || b == 8'hFE)) begin
        kbad = 1; b = 8'hFE;
      end
      if (b[4:0] == 5'd28) begin
        case (b[7:5])
          3'd0: s = 10'b0011110100; 3'd1: s = 10'b0011111001;
          3'd2: s = 10'b0011110101; 3'd3: s = 10'b0011110011;
          3'd4: s = 10'b0011110010; 3'd5: s = 10'b0011111010;
          3'd6: s = 10'b0011110110; default: s = 10'b0011111000;
        endcase
      end else begin
        case (b)
          8'hF7: s = 10'b1110101000; 8'hFB: s = 10'b1101101000;
          8'hFD: s = 10'b1011101000; default: s = 10'b0111101000;
        endcase
      end
      if (rdp) s = ~s;
    end else begin
      p6 = t6(b[4:0]);
      c6 = rdp ? p6[5:0] : p6[11:6];
      rd6 = ($countones(c6) == 3) ? rdp : ($countones(c6) > 3);
      alt = (b[7:5] == 3'd7) &&
            (rd6 ? (b[4:0] == 11 || b[4:0] == 13 || b[4:0] == 14)
                 : (b[4:0] == 17 || b[4:0] == 18 || b[4:0] == 20));
      p4 = t4(b[7:5], alt);
      s = {c6, rd6 ? p4[3:0] : p4[7:4]};
    end
    n = $countones(s);
    nrd = (n == 5) ? rdp : (n > 5);
    for (int i = 0; i < 10; i++) c[i] = s[9-i];
    return {kbad, nrd, c};
  endfunction

  function automatic logic [9:0] rnd_word(input bit raw);
    logic [9:0] w;
    w = 10'($urandom);
    if (!raw && w[8] && ($urandom % 4 != 0)) w[7:0] = kbyte(int'($urandom % 12));
    return w;
  endfunction

  // sample outputs of the current cycle and score transfers
  task automatic observe();
    logic [11:0] r;
    logic [9:0] w;
    string tag;
    bit st;
    if (sync_mode)
      chk(in_ready == '0 || in_ready == '1, "R9 ready equal", {7'd0, in_ready}, {7'd0, in_ready[0] ? 4'hF : 4'h0});
    for (int l = 0; l < L; l++) begin
      if (held_v[l])
        chk(out_valid[l] && out_code[l*10 +: 10] == held_c[l], $sformatf("R8 hold lane%0d", l),
            {out_valid[l], out_code[l*10 +: 10]}, {1'b1, held_c[l]});
      if (out_valid[l] && out_ready[l]) begin
        if (rp[l] == wp[l]) begin
          chk(0, $sformatf("R7 extra group lane%0d", l), {bad_k[l], out_code[l*10 +: 10]}, 11'd0);
        end else begin
          w = fq[l][rp[l] % 256];
          rp[l]++;
          if (raw_mode) begin
            r = {2'b00, w};
            tag = "R1";
          end else begin
            r = ref_enc(w, rdm[l]);
            rdm[l] = r[10];
            tag = !w[8] ? "R2 R4" : (r[11] ? "R6" : "R3");
          end
          tag = $sformatf("%s R5 R7 %s lane%0d", tag, sync_mode ? "R9" : "R10", l);
          chk({bad_k[l], out_code[l*10 +: 10]} == {r[11], r[9:0]}, tag,
              {bad_k[l], out_code[l*10 +: 10]}, {r[11], r[9:0]});
          if (l == 0 && lgn < 64) begin lg[lgn] = out_code[9:0]; lgn++; end
        end
      end
      held_v[l] = out_valid[l] && !out_ready[l];
      held_c[l] = out_code[l*10 +: 10];
      st = sync_mode ? in_valid[0] : in_valid[l];
      if (st && in_ready[l]) begin
        fq[l][wp[l] % 256] = in_rise[l*10 +: 10];
        fq[l][(wp[l] + 1) % 256] = in_fall[l*10 +: 10];
        wp[l] += 2;
      end
    end
  endtask

  task automatic rand_cycle(input int vpct, input int rpct);
    @(negedge clk);
    for (int l = 0; l < L; l++) begin
      in_valid[l]  = ($urandom % 100) < vpct;
      in_rise[l*10 +: 10] = rnd_word(raw_mode);
      in_fall[l*10 +: 10] = rnd_word(raw_mode);
      out_ready[l] = ($urandom % 100) < rpct;
    end
    #1 observe();
  endtask

  task automatic drain();
    for (int c = 0; c < 16; c++) rand_cycle(0, 100);
  endtask

  task automatic push0(input logic [9:0] r, input logic [9:0] f);
    bit acc;
    acc = 0;
    while (!acc) begin
      @(negedge clk);
      in_valid = 4'b0001;
      in_rise[9:0] = r;
      in_fall[9:0] = f;
      out_ready = '1;
      #1 acc = in_ready[0];
      observe();
    end
  endtask

  initial begin
    void'($urandom(1234));
    rst_n = 0; raw_mode = 0; sync_mode = 0;
    in_valid = '0; out_ready = '0; in_rise = '0; in_fall = '0;
    for (int l = 0; l < L; l++) begin wp[l] = 0; rp[l] = 0; rdm[l] = 0; held_v[l] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    // R11: reset state
    chk(out_valid == '0, "R11 out_valid after reset", {7'd0, out_valid}, 11'd0);
    chk(in_ready == '1, "R11 in_ready after reset", {7'd0, in_ready}, 11'hF);

    // R5: first group from negative column, K28.5 then its complement
    push0(10'h1BC, 10'h1BC);
    drain();
    chk(lg[0] == 10'b0101111100, "R5 first K28.5 negative column", {1'b0, lg[0]}, 11'h17C);
    chk(lg[1] == ~lg[0], "R5 second K28.5 positive column", {1'b0, lg[1]}, {1'b0, ~lg[0]});

    // R3: every legal K byte; R6: illegal K with bit 9 set; R4: bit 9 toggled on data
    for (int i = 0; i < 12; i += 2) push0({2'b01, kbyte(i)}, {2'b11, kbyte(i + 1)});
    push0(10'h300, 10'h155);
    push0(10'h241, 10'h041);
    drain();
    chk(rp[0] == wp[0], "R7 directed all delivered", 11'(rp[0]), 11'(wp[0]));

    // independent lanes, encode, random back-pressure (R10)
    for (int c = 0; c < 3000; c++) rand_cycle(60, 70);
    drain();
    // independent lanes, raw (R1)
    raw_mode = 1;
    for (int c = 0; c < 2000; c++) rand_cycle(60, 60);
    drain();
    // sync lanes, encode (R9); disparity carried over raw phase (R5)
    raw_mode = 0; sync_mode = 1;
    for (int c = 0; c < 3000; c++) rand_cycle(50, 80);
    drain();
    // sync lanes, raw
    raw_mode = 1;
    for (int c = 0; c < 2000; c++) rand_cycle(50, 50);
    drain();
    for (int l = 0; l < L; l++)
      chk(rp[l] == wp[l], $sformatf("R7 all delivered lane%0d", l), 11'(rp[l]), 11'(wp[l]));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R7 act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule